// File: doc/BRIEF.md
# Selectable Sync Detector with Stripping

This block sits behind the character assembler of one receive line. It watches the stream of whole received characters and decides when the line becomes synchronized. Once the line is synchronized, it decides for each character whether that character is passed to the receive buffer. The number of sync characters that must be seen is selectable: either one, or two in direct succession. Leading sync characters can optionally be suppressed. Suppression lasts only until the first non-sync character arrives. After that, everything is passed on, including later sync codes.

In asynchronous mode no sync code is searched for. The line becomes active as soon as the receiver is enabled, and the block produces its own match pulse. A resync pulse drops the active state. In synchronous mode the pulse restarts the hunt. In asynchronous mode it shuts the line down until the receiver enable is cycled.

Top module: `sync_hunt_strip`

## Requirements
- R1: In synchronous single-sync mode (`dual_sync_sel`=0), a valid character equal to `sync_code` seen while hunting makes `line_active` 1 after that clock edge. `match_pulse` is 1 for exactly that one cycle. The synchronizing character itself is not forwarded.
- R2: In synchronous double-sync mode (`dual_sync_sel`=1), the line becomes active only on the second of two consecutive valid sync characters. `match_pulse` is raised for one cycle at that point.
- R3: In double-sync mode, a valid non-sync character that follows a lone sync character returns the search to its start. After that, two fresh consecutive sync characters are required.
- R4: If `strip_en` is 1 at the moment synchronization is reached, a strip state is entered. While it holds, valid sync characters produce no `store_en`.
- R5: The strip state ends at the first valid non-sync character, and that character is forwarded. From then on, sync characters are forwarded too. With `strip_en`=0, every character after synchronization is forwarded.
- R6: Each valid character accepted while active gives `store_en`=1 for one cycle after its edge, with `store_data` equal to the character. Cycles without `char_valid` give no `store_en`.
- R7: In synchronous mode, `resync_pulse` makes `line_active` 0 after the edge. A character in that same cycle is dropped, and the hunt restarts.
- R8: While `rx_enable` is 0, the line is inactive, no characters are forwarded and no sync is detected.
- R9: In asynchronous mode (`async_mode`=1), with `rx_enable`=1, the line becomes active one edge later with a one-cycle `match_pulse`, without any character being received.
- R10: In asynchronous mode, `resync_pulse` shuts the line down. It stays inactive while `rx_enable` stays 1, and restarts only after `rx_enable` has been 0 and then 1 again.
- R11: After reset, `line_active`, `match_pulse` and `store_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | Strobe: `char_data` holds a new character |
| char_data | input | CHAR_W | Received character |
| sync_code | input | CHAR_W | Programmed sync character |
| dual_sync_sel | input | 1 | 0: one sync character, 1: two consecutive |
| strip_en | input | 1 | Suppress leading sync characters |
| rx_enable | input | 1 | Receiver enable |
| async_mode | input | 1 | 1: asynchronous line, 0: synchronous |
| resync_pulse | input | 1 | Restart the hunt (sync) or shut down (async) |
| line_active | output | 1 | Line synchronized and receiving |
| match_pulse | output | 1 | One-cycle pulse when synchronization is reached |
| store_en | output | 1 | Forward `store_data` to the receive buffer |
| store_data | output | CHAR_W | Forwarded character |

## Verification
The hunt is tested with several character patterns. A non-sync character before any sync shows that arbitrary data never synchronizes the line. A sync character, then data, then a sync character in double-sync mode separates a correct return to the start from a detector that merely remembers having seen one sync. Runs of sync characters after synchronization, followed by data and then a further sync code, distinguish stripping that ends at the first non-sync character from stripping that never ends or never starts. With stripping off, the same runs must all be forwarded. A resync in the middle of a data block, and a resync in asynchronous mode with the enable held high, show the difference between a restarted hunt and a shutdown.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_ONE    = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_SHUT   = 2'd3
  } hunt_state_t;
endpackage

// File: rtl/sync_code_cmp.sv
module sync_code_cmp #(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0] char_data,
  input  logic [CHAR_W-1:0] sync_code,
  output logic              is_sync
);
  logic [CHAR_W-1:0] bit_eq;

  for (genvar b = 0; b < CHAR_W; b++) begin : g_bit
    assign bit_eq[b] = ~(char_data[b] ^ sync_code[b]);
  end

  assign is_sync = &bit_eq;
endmodule

// File: rtl/sync_hunt_fsm.sv
module sync_hunt_fsm
  import sync_hunt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic char_valid,
  input  logic is_sync,
  input  logic dual_sync_sel,
  input  logic rx_enable,
  input  logic async_mode,
  input  logic resync_pulse,
  output logic sync_evt,
  output logic fwd_ok,
  output logic line_active,
  output logic match_pulse
);
  hunt_state_t state_q, state_d;
  logic        match_q;

  always_comb begin
    state_d  = state_q;
    sync_evt = 1'b0;
    if (!rx_enable) begin
      state_d = ST_HUNT;
    end else if (resync_pulse) begin
      state_d = async_mode ? ST_SHUT : ST_HUNT;
    end else begin
      case (state_q)
        ST_HUNT: begin
          if (async_mode) begin
            state_d  = ST_ACTIVE;
            sync_evt = 1'b1;
          end else if (char_valid && is_sync) begin
            if (dual_sync_sel) begin
              state_d = ST_ONE;
            end else begin
              state_d  = ST_ACTIVE;
              sync_evt = 1'b1;
            end
          end
        end
        ST_ONE: begin
          if (char_valid) begin
            if (is_sync) begin
              state_d  = ST_ACTIVE;
              sync_evt = 1'b1;
            end else begin
              state_d = ST_HUNT;
            end
          end
        end
        ST_ACTIVE: state_d = ST_ACTIVE;
        ST_SHUT:   state_d = ST_SHUT;
        default:   state_d = ST_HUNT;
      endcase
    end
  end

  assign fwd_ok = (state_q == ST_ACTIVE) && rx_enable && !resync_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      match_q <= 1'b0;
    end else begin
      state_q <= state_d;
      match_q <= sync_evt;
    end
  end

  assign line_active = (state_q == ST_ACTIVE);
  assign match_pulse = match_q;
endmodule

// File: rtl/strip_gate.sv
module strip_gate #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              is_sync,
  input  logic              strip_en,
  input  logic              sync_evt,
  input  logic              fwd_ok,
  output logic              store_en,
  output logic [CHAR_W-1:0] store_data
);
  logic              strip_q, strip_d;
  logic              take;
  logic              store_en_d;
  logic [CHAR_W-1:0] data_q;
  logic              en_q;

  assign take = char_valid && fwd_ok;

  always_comb begin
    strip_d    = strip_q;
    store_en_d = 1'b0;
    if (sync_evt) begin
      strip_d = strip_en;
    end else if (!fwd_ok) begin
      strip_d = 1'b0;
    end else if (take) begin
      if (strip_q && is_sync) begin
        store_en_d = 1'b0;
      end else begin
        store_en_d = 1'b1;
        if (!is_sync) strip_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strip_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      strip_q <= strip_d;
      en_q    <= store_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (store_en_d) begin
      data_q <= char_data;
    end
  end

  assign store_en   = en_q;
  assign store_data = data_q;
endmodule

// File: rtl/sync_hunt_strip.sv
module sync_hunt_strip #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  input  logic [CHAR_W-1:0] sync_code,
  input  logic              dual_sync_sel,
  input  logic              strip_en,
  input  logic              rx_enable,
  input  logic              async_mode,
  input  logic              resync_pulse,
  output logic              line_active,
  output logic              match_pulse,
  output logic              store_en,
  output logic [CHAR_W-1:0] store_data
);
  logic is_sync;
  logic sync_evt;
  logic fwd_ok;

  sync_code_cmp #(.CHAR_W(CHAR_W)) i_cmp (
    .char_data (char_data),
    .sync_code (sync_code),
    .is_sync   (is_sync)
  );

  sync_hunt_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .char_valid    (char_valid),
    .is_sync       (is_sync),
    .dual_sync_sel (dual_sync_sel),
    .rx_enable     (rx_enable),
    .async_mode    (async_mode),
    .resync_pulse  (resync_pulse),
    .sync_evt      (sync_evt),
    .fwd_ok        (fwd_ok),
    .line_active   (line_active),
    .match_pulse   (match_pulse)
  );

  strip_gate #(.CHAR_W(CHAR_W)) i_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .char_data  (char_data),
    .is_sync    (is_sync),
    .strip_en   (strip_en),
    .sync_evt   (sync_evt),
    .fwd_ok     (fwd_ok),
    .store_en   (store_en),
    .store_data (store_data)
  );
endmodule

// File: rtl/sync_hunt_strip_chk.sv
module sync_hunt_strip_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              char_valid,
  input logic [CHAR_W-1:0] char_data,
  input logic              rx_enable,
  input logic              async_mode,
  input logic              resync_pulse,
  input logic              line_active,
  input logic              match_pulse,
  input logic              store_en,
  input logic [CHAR_W-1:0] store_data
);
  // R1
  match_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  // R2
  rise_has_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_active) |-> match_pulse);

  // R6
  store_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> line_active);

  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && line_active && rx_enable && !resync_pulse) |=>
      (!store_en || store_data == $past(char_data)));

  // R7
  resync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |=> !line_active && !store_en);

  // R8
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !line_active && !store_en && !match_pulse);

  // R10
  async_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_mode && !line_active && $past(!line_active) && rx_enable && $past(rx_enable) && !match_pulse && $past(!match_pulse) && $past(resync_pulse)) |=> !line_active);
endmodule

bind sync_hunt_strip sync_hunt_strip_chk #(.CHAR_W(CHAR_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .char_valid   (char_valid),
  .char_data    (char_data),
  .rx_enable    (rx_enable),
  .async_mode   (async_mode),
  .resync_pulse (resync_pulse),
  .line_active  (line_active),
  .match_pulse  (match_pulse),
  .store_en     (store_en),
  .store_data   (store_data)
);

// File: tb/test_sync_hunt_strip.sv
module test_sync_hunt_strip;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [W-1:0] SYN = 8'h16;

  logic         clk;
  logic         rst_n;
  logic         char_valid;
  logic [W-1:0] char_data;
  logic [W-1:0] sync_code;
  logic         dual_sync_sel;
  logic         strip_en;
  logic         rx_enable;
  logic         async_mode;
  logic         resync_pulse;
  logic         line_active;
  logic         match_pulse;
  logic         store_en;
  logic [W-1:0] store_data;

  int n_cmp;
  int n_bad;
  bit done;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  sync_hunt_strip #(.CHAR_W(W)) i_sync_hunt_strip (
    .clk           (clk),
    .rst_n         (rst_n),
    .char_valid    (char_valid),
    .char_data     (char_data),
    .sync_code     (sync_code),
    .dual_sync_sel (dual_sync_sel),
    .strip_en      (strip_en),
    .rx_enable     (rx_enable),
    .async_mode    (async_mode),
    .resync_pulse  (resync_pulse),
    .line_active   (line_active),
    .match_pulse   (match_pulse),
    .store_en      (store_en),
    .store_data    (store_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one character, expected forwarding pushed to the scoreboard
  task automatic send(input logic [W-1:0] ch, input bit fwd, input string tag);
    char_valid = 1'b1;
    char_data  = ch;
    if (fwd) begin
      exp_q.push_back(ch);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    check({tag, " pending"}, W'(exp_q.size()), '0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && store_en) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R6: actual store %0h expected no store at %0t", store_data, $time);
      end else begin
        check(tag_q.pop_front(), store_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; char_valid = 1'b0; char_data = '0; sync_code = SYN;
    dual_sync_sel = 1'b0; strip_en = 1'b1; rx_enable = 1'b1;
    async_mode = 1'b0; resync_pulse = 1'b0;
    idle(3);
    // R11 reset state
    check("R11 line", W'(line_active), 0);
    check("R11 match", W'(match_pulse), 0);
    check("R11 store", W'(store_en), 0);
    rst_n = 1'b1;
    idle(2);

    // single sync, strip on
    send(8'h55, 0, "R1");
    check("R1 no sync on data", W'(line_active), 0);
    send(SYN, 0, "R1");
    check("R1 line", W'(line_active), 1);
    check("R1 match", W'(match_pulse), 1);
    send(SYN, 0, "R4");
    check("R1 match once", W'(match_pulse), 0);
    send(SYN, 0, "R4");
    idle(2);
    send(8'h41, 1, "R5");
    send(SYN, 1, "R5");
    send(8'h42, 1, "R6");
    idle(2);
    drained("R4");

    // resync mid-block
    resync_pulse = 1'b1;
    char_valid = 1'b1; char_data = 8'h77;
    @(negedge clk);
    resync_pulse = 1'b0; char_valid = 1'b0;
    check("R7 line dropped", W'(line_active), 0);
    send(8'h43, 0, "R7");
    check("R7 still hunting", W'(line_active), 0);
    send(SYN, 0, "R7");
    check("R7 hunt restarted", W'(line_active), 1);
    send(8'h44, 1, "R7");
    idle(2);
    drained("R7");

    // double sync, strip off
    resync_pulse = 1'b1; @(negedge clk); resync_pulse = 1'b0;
    dual_sync_sel = 1'b1; strip_en = 1'b0;
    send(SYN, 0, "R2");
    check("R2 one sync not enough", W'(line_active), 0);
    send(8'h44, 0, "R3");
    send(SYN, 0, "R3");
    check("R3 search restarted", W'(line_active), 0);
    send(SYN, 0, "R2");
    check("R2 line", W'(line_active), 1);
    check("R2 match", W'(match_pulse), 1);
    send(SYN, 1, "R5");
    send(8'h45, 1, "R5");
    send(SYN, 1, "R5");
    idle(2);
    drained("R5");

    // receiver disabled
    rx_enable = 1'b0;
    @(negedge clk);
    check("R8 line off", W'(line_active), 0);
    send(SYN, 0, "R8");
    send(SYN, 0, "R8");
    check("R8 no sync", W'(line_active), 0);
    check("R8 no match", W'(match_pulse), 0);
    idle(2);
    drained("R8");

    // asynchronous line
    async_mode = 1'b1; dual_sync_sel = 1'b0;
    rx_enable = 1'b1;
    @(negedge clk);
    check("R9 line", W'(line_active), 1);
    check("R9 match", W'(match_pulse), 1);
    send(SYN, 1, "R9");
    send(8'h30, 1, "R9");
    idle(2);
    drained("R9");
    resync_pulse = 1'b1; @(negedge clk); resync_pulse = 1'b0;
    check("R10 shut", W'(line_active), 0);
    idle(4);
    check("R10 stays shut", W'(line_active), 0);
    send(8'h31, 0, "R10");
    rx_enable = 1'b0; @(negedge clk);
    rx_enable = 1'b1; @(negedge clk);
    check("R10 restart", W'(line_active), 1);
    send(8'h32, 1, "R10");
    idle(2);
    drained("R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule